// File: doc/BRIEF.md
# Translate-then-Lookup Byte Access Unit

This unit turns a 14-bit virtual address into one byte of data in two chained steps. The virtual page number is first checked against a small set-associative translation buffer. If that misses, the unit falls back to a local page table indexed by the page number. The resulting page frame number is joined to the untouched 6-bit page offset to form a 12-bit physical address. That address then indexes a direct-mapped, physically tagged data cache.

Each request produces one result with four separate outcomes: whether the translation buffer hit, whether the page was missing (a fault), whether the cache hit, and the byte found. The physical address is reported too. A translation that came from the page table is written back into the translation buffer. A side load port writes any buffer entry, page-table entry or cache line directly, so a caller or a test can set up state. The unit does not service faults, does not fetch missing cache lines from memory, and does not handle stores.

Top module: `vmem_access_unit`

## Requirements
- R1: After reset `req_ready` is 1, `resp_done` is 0, and every translation-buffer entry, page-table entry and cache line is invalid. The first lookup after reset therefore reports a fault.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 for the next cycle. `resp_done` is then a one-cycle pulse that appears after the second rising edge counted from acceptance. `req_ready` is 1 again in that same cycle, and all result outputs are valid while `resp_done` is 1.
- R3: The page number is `vaddr[13:6]`. Its low 2 bits select one of 4 buffer sets and its upper 6 bits are the tag. A valid entry in that set with a matching tag is a hit (`resp_tlb_hit`=1). The lowest-numbered matching way supplies the frame number, and the page table is not consulted.
- R4: On a buffer miss where the page-table entry for the page number is valid, `resp_tlb_hit`=0 and `resp_fault`=0, and the frame number comes from the page table.
- R5: On a buffer miss where the page-table entry is invalid, `resp_fault`=1, and `resp_cache_hit`, `resp_byte` and `resp_paddr` are all 0.
- R6: When there is no fault, `resp_paddr` = {frame number (6 bits), `vaddr[5:0]`}.
- R7: The cache line index is `paddr[5:2]`, the tag is `paddr[11:6]` and the byte offset is `paddr[1:0]`. A valid line with a matching tag is a hit, and it returns byte k = data bits [8k+7:8k] for k = `paddr[1:0]`. A cache miss returns `resp_byte`=0.
- R8: A buffer miss with a valid page-table entry writes the translation into the indexed set. It goes into the lowest-numbered invalid way, so a repeat of the same address hits.
- R9: If every way of the set is valid, the refill goes to that set's round-robin pointer way, and the pointer then advances by one (modulo 4). Every pointer is 0 after reset.
- R10: A load is applied on the rising edge where `ld_en`=1. `ld_target` selects where it goes: 0 = buffer entry (`ld_index[1:0]` set, `ld_way`, `ld_tag`, `ld_ppn`, `ld_valid`), 1 = page-table entry (`ld_index` page number, `ld_ppn`, `ld_valid`), 2 = cache line (`ld_index[3:0]`, `ld_tag`, `ld_data`, `ld_valid`), 3 = no effect. A load on the acceptance edge is seen by that request's lookup.
- R11: If a load and a refill write the same buffer set and way on the same edge, the loaded contents remain.
- R12: While `req_ready` is 0, `req_valid` and `req_vaddr` are ignored. The result belongs to the address captured at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 14 | Virtual address of the request |
| req_ready | output | 1 | Unit idle, a request can be taken |
| resp_done | output | 1 | One-cycle pulse, results valid |
| resp_tlb_hit | output | 1 | Translation buffer hit |
| resp_fault | output | 1 | Page missing in buffer and page table |
| resp_cache_hit | output | 1 | Data cache hit |
| resp_byte | output | 8 | Returned byte, 0 on miss or fault |
| resp_paddr | output | 12 | Physical address, 0 on fault |
| ld_en | input | 1 | Load strobe |
| ld_target | input | 2 | 0 buffer, 1 page table, 2 cache, 3 none |
| ld_index | input | 8 | Set, page number or line index |
| ld_way | input | 2 | Buffer way for buffer loads |
| ld_valid | input | 1 | Valid bit written |
| ld_tag | input | 6 | Buffer tag or cache tag |
| ld_ppn | input | 6 | Frame number for buffer or page table |
| ld_data | input | 32 | Cache line bytes, byte 0 in bits [7:0] |

## Verification
Two writes can land on the same edge. One is the refill that a lookup makes in its busy cycle; the other is a load from the side port. The bench provokes this in two ways. A directed sequence loads exactly the set and way the refill will pick. A randomized phase drives requests and loads together every cycle, with page numbers kept to a small range so that they collide often. A behavioural model evaluates the lookup first, then the refill, then the load, and every later result is compared against it. In this way a wrong priority, or a lookup that sees a load too early or too late, shows up as a mismatched hit flag or frame number.

// File: rtl/vmem_pkg.sv
package vmem_pkg;
  parameter int VA_W      = 14;
  parameter int PA_W      = 12;
  parameter int OFF_W     = 6;
  parameter int TLB_SETS  = 4;
  parameter int TLB_WAYS  = 4;
  parameter int LINES     = 16;
  parameter int BLK_BYTES = 4;

  localparam int VPN_W    = VA_W - OFF_W;
  localparam int PPN_W    = PA_W - OFF_W;
  localparam int SET_W    = $clog2(TLB_SETS);
  localparam int WAY_W    = $clog2(TLB_WAYS);
  localparam int TTAG_W   = VPN_W - SET_W;
  localparam int BOFF_W   = $clog2(BLK_BYTES);
  localparam int LINE_W   = $clog2(LINES);
  localparam int CTAG_W   = PA_W - LINE_W - BOFF_W;
  localparam int PT_DEPTH = 1 << VPN_W;
  localparam int BLK_W    = BLK_BYTES * 8;
  localparam int LDTAG_W  = (TTAG_W > CTAG_W) ? TTAG_W : CTAG_W;

  typedef enum logic [1:0] {
    LD_TLB   = 2'd0,
    LD_PT    = 2'd1,
    LD_CACHE = 2'd2,
    LD_NONE  = 2'd3
  } ld_tgt_e;

  function automatic logic [VPN_W-1:0] va_vpn(logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W];
  endfunction

  function automatic logic [SET_W-1:0] vpn_set(logic [VPN_W-1:0] vpn);
    return vpn[SET_W-1:0];
  endfunction

  function automatic logic [TTAG_W-1:0] vpn_tag(logic [VPN_W-1:0] vpn);
    return vpn[VPN_W-1:SET_W];
  endfunction

  function automatic logic [PA_W-1:0] pa_make(logic [PPN_W-1:0] ppn, logic [OFF_W-1:0] off);
    return {ppn, off};
  endfunction

  function automatic logic [LINE_W-1:0] pa_line(logic [PA_W-1:0] pa);
    return pa[BOFF_W +: LINE_W];
  endfunction

  function automatic logic [CTAG_W-1:0] pa_ctag(logic [PA_W-1:0] pa);
    return pa[PA_W-1:BOFF_W+LINE_W];
  endfunction

  function automatic logic [7:0] pick_byte(logic [BLK_W-1:0] blk, logic [BOFF_W-1:0] sel);
    return blk[sel*8 +: 8];
  endfunction

  // lowest invalid way wins; a full set falls back to the rotation pointer
  function automatic logic [WAY_W-1:0] pick_victim(logic [TLB_WAYS-1:0] vld, logic [WAY_W-1:0] rr);
    logic [WAY_W-1:0] v;
    v = rr;
    for (int w = TLB_WAYS - 1; w >= 0; w--) begin
      if (!vld[w]) v = WAY_W'(w);
    end
    return v;
  endfunction
endpackage

// File: rtl/vmem_tlb.sv
module vmem_tlb
  import vmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  input  logic              fill_en,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              ld_en,
  input  logic [SET_W-1:0]  ld_set,
  input  logic [WAY_W-1:0]  ld_way,
  input  logic              ld_valid,
  input  logic [TTAG_W-1:0] ld_tag,
  input  logic [PPN_W-1:0]  ld_ppn
);
  logic [TLB_WAYS-1:0] vld_q [TLB_SETS];
  logic [TTAG_W-1:0]   tag_q [TLB_SETS][TLB_WAYS];
  logic [PPN_W-1:0]    ppn_q [TLB_SETS][TLB_WAYS];
  logic [WAY_W-1:0]    rr_q  [TLB_SETS];

  logic [SET_W-1:0]  set_w;
  logic [TTAG_W-1:0] tag_w;
  logic [WAY_W-1:0]  victim_w;
  logic              set_full_w;

  assign set_w      = vpn_set(lk_vpn);
  assign tag_w      = vpn_tag(lk_vpn);
  assign victim_w   = pick_victim(vld_q[set_w], rr_q[set_w]);
  assign set_full_w = &vld_q[set_w];

  always_comb begin
    lk_hit = 1'b0;
    lk_ppn = '0;
    for (int w = TLB_WAYS - 1; w >= 0; w--) begin
      if (vld_q[set_w][w] && tag_q[set_w][w] == tag_w) begin
        lk_hit = 1'b1;
        lk_ppn = ppn_q[set_w][w];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < TLB_SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
        for (int w = 0; w < TLB_WAYS; w++) begin
          tag_q[s][w] <= '0;
          ppn_q[s][w] <= '0;
        end
      end
    end else begin
      for (int s = 0; s < TLB_SETS; s++) begin
        for (int w = 0; w < TLB_WAYS; w++) begin
          if (ld_en && ld_set == SET_W'(s) && ld_way == WAY_W'(w)) begin
            vld_q[s][w] <= ld_valid;
            tag_q[s][w] <= ld_tag;
            ppn_q[s][w] <= ld_ppn;
          end else if (fill_en && set_w == SET_W'(s) && victim_w == WAY_W'(w)) begin
            vld_q[s][w] <= 1'b1;
            tag_q[s][w] <= tag_w;
            ppn_q[s][w] <= fill_ppn;
          end
        end
      end
      if (fill_en && set_full_w) rr_q[set_w] <= rr_q[set_w] + 1'b1;
    end
  end

  // R8: a refill is only made on a miss
  assert_fill_on_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !lk_hit);

  // R8: a refill not overwritten by a load leaves a valid way behind
  assert_fill_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !(ld_en && ld_set == set_w && ld_way == victim_w))
      |=> vld_q[$past(set_w)][$past(victim_w)]);

  // R9: a refill into a full set advances that set's pointer
  assert_rr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && set_full_w) |=> rr_q[$past(set_w)] == $past(rr_q[set_w]) + 1'b1);
endmodule

// File: rtl/vmem_page_table.sv
module vmem_page_table
  import vmem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] rd_vpn,
  output logic             rd_valid,
  output logic [PPN_W-1:0] rd_ppn,
  input  logic             ld_en,
  input  logic [VPN_W-1:0] ld_vpn,
  input  logic             ld_valid,
  input  logic [PPN_W-1:0] ld_ppn
);
  logic [PT_DEPTH-1:0] vld_q;
  logic [PPN_W-1:0]    ppn_q [PT_DEPTH];

  assign rd_valid = vld_q[rd_vpn];
  assign rd_ppn   = ppn_q[rd_vpn];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld_q <= '0;
    else if (ld_en) vld_q[ld_vpn] <= ld_valid;
  end

  always_ff @(posedge clk) begin
    if (ld_en) ppn_q[ld_vpn] <= ld_ppn;
  end
endmodule

// File: rtl/vmem_dcache.sv
module vmem_dcache
  import vmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   rd_pa,
  output logic              rd_hit,
  output logic [BLK_W-1:0]  rd_blk,
  input  logic              ld_en,
  input  logic [LINE_W-1:0] ld_line,
  input  logic              ld_valid,
  input  logic [CTAG_W-1:0] ld_tag,
  input  logic [BLK_W-1:0]  ld_data
);
  logic [LINES-1:0]  vld_q;
  logic [CTAG_W-1:0] tag_q [LINES];
  logic [BLK_W-1:0]  dat_q [LINES];

  logic [LINE_W-1:0] line_w;
  assign line_w = pa_line(rd_pa);
  assign rd_hit = vld_q[line_w] && (tag_q[line_w] == pa_ctag(rd_pa));
  assign rd_blk = dat_q[line_w];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld_q <= '0;
    else if (ld_en) vld_q[ld_line] <= ld_valid;
  end

  always_ff @(posedge clk) begin
    if (ld_en) begin
      tag_q[ld_line] <= ld_tag;
      dat_q[ld_line] <= ld_data;
    end
  end
endmodule

// File: rtl/vmem_access_unit.sv
module vmem_access_unit
  import vmem_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  output logic               req_ready,
  output logic               resp_done,
  output logic               resp_tlb_hit,
  output logic               resp_fault,
  output logic               resp_cache_hit,
  output logic [7:0]         resp_byte,
  output logic [PA_W-1:0]    resp_paddr,
  input  logic               ld_en,
  input  logic [1:0]         ld_target,
  input  logic [VPN_W-1:0]   ld_index,
  input  logic [WAY_W-1:0]   ld_way,
  input  logic               ld_valid,
  input  logic [LDTAG_W-1:0] ld_tag,
  input  logic [PPN_W-1:0]   ld_ppn,
  input  logic [BLK_W-1:0]   ld_data
);
  typedef enum logic {ST_IDLE, ST_BUSY} state_e;
  state_e         state_q;
  logic [VA_W-1:0] va_q;

  // named events for the checks
  logic             busy_w;
  logic             tlb_hit_w;
  logic [PPN_W-1:0] tlb_ppn_w;
  logic             pt_valid_w;
  logic [PPN_W-1:0] pt_ppn_w;
  logic [PPN_W-1:0] ppn_w;
  logic             fault_w;
  logic             refill_w;
  logic [PA_W-1:0]  paddr_w;
  logic             c_hit_raw_w;
  logic [BLK_W-1:0] c_blk_w;
  logic             cache_hit_w;
  logic [7:0]       byte_w;
  logic             ld_tlb_w, ld_pt_w, ld_cache_w;

  assign busy_w     = (state_q == ST_BUSY);
  assign req_ready  = (state_q == ST_IDLE);
  assign ld_tlb_w   = ld_en && (ld_target == LD_TLB);
  assign ld_pt_w    = ld_en && (ld_target == LD_PT);
  assign ld_cache_w = ld_en && (ld_target == LD_CACHE);

  vmem_tlb u_tlb (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_vpn   (va_vpn(va_q)),
    .lk_hit   (tlb_hit_w),
    .lk_ppn   (tlb_ppn_w),
    .fill_en  (refill_w),
    .fill_ppn (pt_ppn_w),
    .ld_en    (ld_tlb_w),
    .ld_set   (ld_index[SET_W-1:0]),
    .ld_way   (ld_way),
    .ld_valid (ld_valid),
    .ld_tag   (ld_tag[TTAG_W-1:0]),
    .ld_ppn   (ld_ppn)
  );

  vmem_page_table u_pt (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_vpn   (va_vpn(va_q)),
    .rd_valid (pt_valid_w),
    .rd_ppn   (pt_ppn_w),
    .ld_en    (ld_pt_w),
    .ld_vpn   (ld_index),
    .ld_valid (ld_valid),
    .ld_ppn   (ld_ppn)
  );

  assign fault_w  = !tlb_hit_w && !pt_valid_w;
  assign refill_w = busy_w && !tlb_hit_w && pt_valid_w;
  assign ppn_w    = tlb_hit_w ? tlb_ppn_w : pt_ppn_w;
  assign paddr_w  = fault_w ? '0 : pa_make(ppn_w, va_q[OFF_W-1:0]);

  vmem_dcache u_dc (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_pa    (paddr_w),
    .rd_hit   (c_hit_raw_w),
    .rd_blk   (c_blk_w),
    .ld_en    (ld_cache_w),
    .ld_line  (ld_index[LINE_W-1:0]),
    .ld_valid (ld_valid),
    .ld_tag   (ld_tag[CTAG_W-1:0]),
    .ld_data  (ld_data)
  );

  assign cache_hit_w = !fault_w && c_hit_raw_w;
  assign byte_w      = cache_hit_w ? pick_byte(c_blk_w, paddr_w[BOFF_W-1:0]) : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      va_q           <= '0;
      resp_done      <= 1'b0;
      resp_tlb_hit   <= 1'b0;
      resp_fault     <= 1'b0;
      resp_cache_hit <= 1'b0;
      resp_byte      <= '0;
      resp_paddr     <= '0;
    end else begin
      resp_done <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          state_q <= ST_BUSY;
        end
        default: begin
          state_q        <= ST_IDLE;
          resp_done      <= 1'b1;
          resp_tlb_hit   <= tlb_hit_w;
          resp_fault     <= fault_w;
          resp_cache_hit <= cache_hit_w;
          resp_byte      <= byte_w;
          resp_paddr     <= paddr_w;
        end
      endcase
    end
  end

  assert_done_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> ##2 resp_done);

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> !resp_done);

  assert_busy_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_fault_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_done && resp_fault) |-> (!resp_cache_hit && !resp_tlb_hit && resp_byte == 8'h00 && resp_paddr == '0));

  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_done && !resp_cache_hit) |-> resp_byte == 8'h00);

  assert_offset_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_done && !resp_fault) |-> resp_paddr[OFF_W-1:0] == $past(va_q[OFF_W-1:0]));
endmodule

// File: tb/vmem_access_unit_test.sv
`timescale 1ns/1ps
module vmem_access_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [13:0] req_vaddr = '0;
  logic        req_ready, resp_done, resp_tlb_hit, resp_fault, resp_cache_hit;
  logic [7:0]  resp_byte;
  logic [11:0] resp_paddr;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_target = '0;
  logic [7:0]  ld_index = '0;
  logic [1:0]  ld_way = '0;
  logic        ld_valid = 1'b0;
  logic [5:0]  ld_tag = '0;
  logic [5:0]  ld_ppn = '0;
  logic [31:0] ld_data = '0;

  always #5 clk = ~clk;

  vmem_access_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_ready(req_ready), .resp_done(resp_done), .resp_tlb_hit(resp_tlb_hit),
    .resp_fault(resp_fault), .resp_cache_hit(resp_cache_hit), .resp_byte(resp_byte),
    .resp_paddr(resp_paddr), .ld_en(ld_en), .ld_target(ld_target), .ld_index(ld_index),
    .ld_way(ld_way), .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_ppn(ld_ppn), .ld_data(ld_data)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_tv [4][4]; int m_tt [4][4]; int m_tp [4][4]; int m_rr [4];
  int m_pv [256];  int m_pp [256];
  int m_cv [16];   int m_ct [16];   int m_cd [16];
  int m_busy = 0, m_done = 0, m_va = 0;
  int e_hit = 0, e_fault = 0, e_chit = 0, e_byte = 0, e_pa = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_tv[s, w]) begin m_tv[s][w] = 0; m_tt[s][w] = 0; m_tp[s][w] = 0; end
      foreach (m_rr[s]) m_rr[s] = 0;
      foreach (m_pv[i]) m_pv[i] = 0;
      foreach (m_cv[i]) m_cv[i] = 0;
      m_busy = 0; m_done = 0;
    end else begin
      if (m_busy != 0) begin
        int vpn, st, tg, ppn, line, vic, full;
        vpn = m_va / 64; st = vpn % 4; tg = vpn / 4;
        e_hit = 0; ppn = 0;
        for (int w = 3; w >= 0; w--)
          if (m_tv[st][w] != 0 && m_tt[st][w] == tg) begin e_hit = 1; ppn = m_tp[st][w]; end
        if (e_hit == 0 && m_pv[vpn] != 0) begin
          ppn = m_pp[vpn];
          vic = -1; full = 1;
          for (int w = 0; w < 4; w++)
            if (m_tv[st][w] == 0 && vic < 0) begin vic = w; full = 0; end
          if (full != 0) begin vic = m_rr[st]; m_rr[st] = (m_rr[st] + 1) % 4; end
          m_tv[st][vic] = 1; m_tt[st][vic] = tg; m_tp[st][vic] = ppn;
        end
        e_fault = (e_hit == 0 && m_pv[vpn] == 0) ? 1 : 0;
        e_pa = (e_fault != 0) ? 0 : ppn * 64 + (m_va % 64);
        line = (e_pa / 4) % 16;
        e_chit = (e_fault == 0 && m_cv[line] != 0 && m_ct[line] == e_pa / 64) ? 1 : 0;
        e_byte = (e_chit != 0) ? ((m_cd[line] >> (8 * (e_pa % 4))) & 255) : 0;
        m_done = 1; m_busy = 0;
      end else begin
        m_done = 0;
        if (req_valid) begin m_busy = 1; m_va = int'(req_vaddr); end
      end
      if (ld_en) begin
        case (ld_target)
          2'd0: begin
            m_tv[ld_index % 4][ld_way] = ld_valid;
            m_tt[ld_index % 4][ld_way] = ld_tag;
            m_tp[ld_index % 4][ld_way] = ld_ppn;
          end
          2'd1: begin m_pv[ld_index] = ld_valid; m_pp[ld_index] = ld_ppn; end
          2'd2: begin
            m_cv[ld_index % 16] = ld_valid; m_ct[ld_index % 16] = ld_tag;
            m_cd[ld_index % 16] = int'(ld_data);
          end
          default: ;
        endcase
      end
    end
  end

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2/R12 ready", int'(req_ready), (m_busy == 0) ? 1 : 0);
      chk("R2 done", int'(resp_done), m_done);
      if (m_done != 0) begin
        chk("R3/R4 tlb_hit", int'(resp_tlb_hit), e_hit);
        chk("R5 fault", int'(resp_fault), e_fault);
        chk("R7 cache_hit", int'(resp_cache_hit), e_chit);
        chk("R7 byte", int'(resp_byte), e_byte);
        chk("R6 paddr", int'(resp_paddr), e_pa);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_req(input logic [13:0] va);
    @(negedge clk); req_valid = 1'b1; req_vaddr = va;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_ld(input int tgt, input int idx, input int way, input int v,
                        input int tag, input int ppn, input int data);
    ld_en = 1'b1; ld_target = 2'(tgt); ld_index = 8'(idx); ld_way = 2'(way);
    ld_valid = 1'(v); ld_tag = 6'(tag); ld_ppn = 6'(ppn); ld_data = 32'(data);
  endtask

  task automatic load(input int tgt, input int idx, input int way, input int v,
                      input int tag, input int ppn, input int data);
    @(negedge clk); set_ld(tgt, idx, way, v, tag, ppn, data);
    @(negedge clk); ld_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(req_ready), 1);
    chk("R1 done after reset", int'(resp_done), 0);

    do_req(14'h03D4);
    chk("R1 empty tables fault", int'(resp_fault), 1);
    chk("R5 fault byte", int'(resp_byte), 0);

    load(1, 8'h0F, 0, 1, 0, 6'h0D, 0);
    load(2, 5, 0, 1, 6'h0D, 0, 32'h44332211);
    do_req(14'h03D4);
    chk("R4 miss via table", int'(resp_tlb_hit), 0);
    chk("R4 no fault", int'(resp_fault), 0);
    chk("R6 paddr", int'(resp_paddr), 12'h354);
    chk("R7 byte0", int'(resp_byte), 8'h11);
    do_req(14'h03D4);
    chk("R8 refill hits", int'(resp_tlb_hit), 1);
    do_req(14'h03D7);
    chk("R7 byte3", int'(resp_byte), 8'h44);
    do_req(14'h03D8);
    chk("R7 cache miss", int'(resp_cache_hit), 0);

    // R3: buffer entry wins without a page-table entry
    load(0, 0, 0, 1, 6'h01, 6'h0D, 0);
    do_req(14'h0114);
    chk("R3 hit", int'(resp_tlb_hit), 1);
    chk("R3 paddr", int'(resp_paddr), 12'h354);

    // R9: full set 1, two refills rotate ways 0 then 1
    for (int w = 0; w < 4; w++) load(0, 1, w, 1, 6'h10 + w, 6'h01, 0);
    load(1, 8'h81, 0, 1, 0, 6'h02, 0);
    load(1, 8'hC1, 0, 1, 0, 6'h03, 0);
    do_req(14'h2040);
    do_req(14'h1040);
    chk("R9 way0 evicted", int'(resp_fault), 1);
    do_req(14'h1140);
    chk("R9 way1 kept", int'(resp_tlb_hit), 1);
    do_req(14'h3040);
    do_req(14'h1140);
    chk("R9 way1 evicted", int'(resp_fault), 1);

    // R10: target 3 has no effect
    load(3, 8'h0F, 0, 0, 0, 0, 0);
    do_req(14'h03D4);
    chk("R10 none target", int'(resp_byte), 8'h11);

    // R10: load on the acceptance edge is seen
    @(negedge clk); req_valid = 1'b1; req_vaddr = 14'h0020; set_ld(1, 0, 0, 1, 0, 6'h28, 0);
    @(negedge clk); req_valid = 1'b0; ld_en = 1'b0;
    @(negedge clk);
    chk("R10 same-edge load", int'(resp_fault), 0);
    chk("R10 paddr", int'(resp_paddr), 12'hA20);

    // R11: load collides with refill in set 2 way 0
    load(1, 8'h06, 0, 1, 0, 6'h07, 0);
    @(negedge clk); req_valid = 1'b1; req_vaddr = 14'h0180;
    @(negedge clk); req_valid = 1'b0; set_ld(0, 2, 0, 1, 6'h3F, 6'h05, 0);
    @(negedge clk); ld_en = 1'b0;
    chk("R11 collide paddr", int'(resp_paddr), 12'h1C0);
    do_req(14'h3F80);
    chk("R11 load kept", int'(resp_tlb_hit), 1);
    chk("R11 load ppn", int'(resp_paddr), 12'h140);

    // R12: held request while busy is ignored
    @(negedge clk); req_valid = 1'b1; req_vaddr = 14'h03D4;
    @(negedge clk); req_vaddr = 14'h0000;
    @(negedge clk); req_valid = 1'b0;
    chk("R12 captured addr", int'(resp_paddr), 12'h354);
    repeat (3) @(negedge clk);

    // randomized overlap of requests and loads
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      req_valid = 1'($urandom % 2);
      req_vaddr = {4'($urandom % 16 < 8 ? 0 : $urandom), 4'($urandom), 6'($urandom)};
      if ($urandom % 2 != 0)
        set_ld($urandom % 4, $urandom % 16, $urandom % 4, ($urandom % 4) != 0,
               $urandom % 64, $urandom % 64, $urandom);
      else
        ld_en = 1'b0;
    end
    @(negedge clk); req_valid = 1'b0; ld_en = 1'b0;
    repeat (4) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule